// File: doc/BRIEF.md
# Interrupt Vector Table Controller

This block holds a table of message-signalled interrupt vectors and a bit array of pending vectors, both inside one 4 KB register window that software reaches over a simple 32-bit register bus. Each vector owns a 16-byte entry. The entry holds a 64-bit target address, a 32-bit payload word and a control word whose bit 0 masks the vector. When device logic raises a request for a vector, the block either writes the payload to the target address through a valid/ready message port or, if the vector is masked, records it as pending. A later table write that unmasks the vector releases that pending message.

Device logic must declare which vectors it uses. A small command port raises or lowers a per-vector usage count. A vector whose count is zero never delivers and never becomes pending. Releasing the last use of a vector discards its pending state. A global enable bit in a flags word, which also reports the table size, gates all delivery.

Top module: `irq_vector_table`

## Requirements
- R1: Entry v occupies window offset 16*v. Word 0 is the address low half, word 1 the address high half, word 2 the payload and word 3 the control word. Bit 0 of the control word is the mask (1 = masked). Every word reads back what was written to it.
- R2: The word at offset 0x800 reads the pending bits, with vector v at bit v (bit v mod 8 of byte v div 8). Writes to it have no effect.
- R3: Only accesses with size code 2 (word) write. Size codes 0 (byte), 1 (halfword) and 3 write nothing. Address bits [1:0] are ignored, and the offset is the address modulo 4096.
- R4: The flags word at offset 0xFFC reads NUM_VEC-1 in bits [10:0] and the enable bit in bit 15. Bit 15 is the only writable bit. All other bits read 0.
- R5: A request is dropped, with no message and no pending bit, if its vector is at or above NUM_VEC, has a usage count of zero, or arrives while enable is 0.
- R6: An accepted request for a masked vector sets its pending bit. For an unmasked vector it sends one message with address {high, low} and data equal to the payload.
- R7: After a word write into entry v, if v is unmasked and its pending bit is set, the pending bit clears and v's message is sent.
- R8: Reset clears every address, payload and control word, all pending bits and the enable bit, then sets the mask bit of every configured entry.
- R9: Usage commands on use_op_i: 1 increments the count of use_vec_i (ignored for vectors at or above NUM_VEC), 2 decrements it (ignored at zero) and clears the pending bit when the count reaches zero, 3 zeroes every count and clears every pending bit.
- R10: While msg_valid_o is high and msg_ready_i is low, msg_valid_o, msg_addr_o and msg_data_o hold. A new message loads only when the port is empty or is being accepted.
- R11: Releases of pending vectors go out before queued requests. Among requests waiting together, the lowest vector number goes first.
- R12: Offsets below 0x800 that fall beyond the configured entries read 0 and ignore writes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| reg_req_i | input | 1 | Register access strobe |
| reg_we_i | input | 1 | Access is a write |
| reg_size_i | input | 2 | Access size: 0 byte, 1 halfword, 2 word |
| reg_addr_i | input | 32 | Access address |
| reg_wdata_i | input | 32 | Write data |
| reg_rdata_o | output | 32 | Read data for reg_addr_i (combinational) |
| evt_req_i | input | 32 | One request bit per vector number |
| use_op_i | input | 2 | Usage command: 0 none, 1 use, 2 unuse, 3 unuse all |
| use_vec_i | input | 5 | Vector targeted by a use or unuse command |
| msg_valid_o | output | 1 | Message available |
| msg_ready_i | input | 1 | Message accepted |
| msg_addr_o | output | 64 | Message target address |
| msg_data_o | output | 32 | Message payload |

## Verification
Checks that run on every cycle cover the message port: a stalled message holds its address and data, and no new message starts while enable is low. They also check that no vector is pending without a nonzero usage count, that no count drops below zero, and that the dispatcher grants at most one source at a time. The scenarios are needed to show the table layout and sub-word write suppression, reset values, the drop rules for unused or disabled vectors, and the pending release on an unmasking write. They also show the delivery order when a release competes with several queued requests, and that pending state is discarded by unuse and unuse-all commands.

// File: rtl/ivt_pkg.sv
package ivt_pkg;
  localparam int MAX_VEC = 32;
  localparam int VEC_W   = $clog2(MAX_VEC);
  localparam logic [1:0] SZ_WORD = 2'd2;
  localparam logic [9:0] PEND_WADDR  = 10'h200;  // 0x800 >> 2
  localparam logic [9:0] FLAGS_WADDR = 10'h3FF;  // 0xFFC >> 2

  typedef struct packed {
    logic [31:0] ctrl;
    logic [31:0] data;
    logic [31:0] hi;
    logic [31:0] lo;
  } ivt_entry_t;

  typedef enum logic [1:0] {
    OP_NONE  = 2'd0,
    OP_USE   = 2'd1,
    OP_UNUSE = 2'd2,
    OP_CLEAR = 2'd3
  } use_op_e;
endpackage

// File: rtl/ivt_use_track.sv
module ivt_use_track
  import ivt_pkg::*;
#(
  parameter int NUM_VEC = 8,
  parameter int CNT_W   = 4
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  use_op_e            op_i,
  input  logic [VEC_W-1:0]   vec_i,
  output logic [NUM_VEC-1:0] in_use_o,
  output logic [NUM_VEC-1:0] drop_o
);
  for (genvar v = 0; v < NUM_VEC; v++) begin : g_cnt
    logic [CNT_W-1:0] cnt_q;
    logic             hit;
    assign hit = (vec_i == VEC_W'(v));

    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) cnt_q <= '0;
      else if (op_i == OP_CLEAR) cnt_q <= '0;
      else if (hit && op_i == OP_USE && cnt_q != '1) cnt_q <= cnt_q + 1'b1;
      else if (hit && op_i == OP_UNUSE && cnt_q != '0) cnt_q <= cnt_q - 1'b1;
    end

    assign in_use_o[v] = (cnt_q != '0);
    assign drop_o[v]   = (op_i == OP_CLEAR) ||
                         (op_i == OP_UNUSE && hit && cnt_q == CNT_W'(1));

    p_cnt_floor_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (op_i == OP_UNUSE && hit && cnt_q == '0) |=> (cnt_q == '0));
  end
endmodule

// File: rtl/ivt_table.sv
module ivt_table
  import ivt_pkg::*;
#(
  parameter int NUM_VEC = 8
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               wr_i,
  input  logic [9:0]         waddr_i,
  input  logic [31:0]        wdata_i,
  output logic [31:0]        rdata_o,
  input  logic [NUM_VEC-1:0] evt_i,
  input  logic [NUM_VEC-1:0] in_use_i,
  input  logic [NUM_VEC-1:0] drop_i,
  output logic               en_o,
  output logic [NUM_VEC-1:0] fire_o,
  output logic [NUM_VEC-1:0] rel_o,
  output ivt_entry_t         tbl_o [NUM_VEC]
);
  logic               en_q;
  logic [NUM_VEC-1:0] pend;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) en_q <= 1'b0;
    else if (wr_i && waddr_i == FLAGS_WADDR) en_q <= wdata_i[15];
  end
  assign en_o = en_q;

  for (genvar v = 0; v < NUM_VEC; v++) begin : g_ent
    ivt_entry_t e_q;
    logic       p_q, hit, new_mask, acc, set_p;

    assign hit      = wr_i && !waddr_i[9] && (waddr_i[8:2] == 7'(v));
    assign new_mask = (waddr_i[1:0] == 2'd3) ? wdata_i[0] : e_q.ctrl[0];
    assign acc      = evt_i[v] && in_use_i[v] && en_q;
    assign set_p    = acc && e_q.ctrl[0];
    assign fire_o[v] = acc && !e_q.ctrl[0];
    assign rel_o[v]  = hit && !new_mask && (p_q || set_p);

    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        e_q <= '{ctrl: 32'd1, data: '0, hi: '0, lo: '0};
      end else if (hit) begin
        case (waddr_i[1:0])
          2'd0:    e_q.lo   <= wdata_i;
          2'd1:    e_q.hi   <= wdata_i;
          2'd2:    e_q.data <= wdata_i;
          default: e_q.ctrl <= wdata_i;
        endcase
      end
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) p_q <= 1'b0;
      else p_q <= (p_q || set_p) && !rel_o[v] && !drop_i[v];
    end

    assign pend[v]  = p_q;
    assign tbl_o[v] = e_q;
  end

  always_comb begin
    rdata_o = '0;
    if (!waddr_i[9]) begin
      for (int v = 0; v < NUM_VEC; v++) begin
        if (waddr_i[8:2] == 7'(v)) begin
          case (waddr_i[1:0])
            2'd0:    rdata_o = tbl_o[v].lo;
            2'd1:    rdata_o = tbl_o[v].hi;
            2'd2:    rdata_o = tbl_o[v].data;
            default: rdata_o = tbl_o[v].ctrl;
          endcase
        end
      end
    end else if (waddr_i == PEND_WADDR) begin
      rdata_o = 32'(pend);
    end else if (waddr_i == FLAGS_WADDR) begin
      rdata_o = {16'h0, en_q, 4'h0, 11'(NUM_VEC - 1)};
    end
  end

  p_pend_in_use_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (pend & ~in_use_i) == '0);
endmodule

// File: rtl/ivt_dispatch.sv
module ivt_dispatch
  import ivt_pkg::*;
#(
  parameter int NUM_VEC = 8
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               en_i,
  input  logic [NUM_VEC-1:0] fire_i,
  input  logic [NUM_VEC-1:0] rel_i,
  input  ivt_entry_t         tbl_i [NUM_VEC],
  output logic               msg_valid_o,
  input  logic               msg_ready_i,
  output logic [63:0]        msg_addr_o,
  output logic [31:0]        msg_data_o
);
  logic [NUM_VEC-1:0] evt_q, rel_q, pool, grant;
  logic               from_rel, load, unused_ctrl;
  ivt_entry_t         sel;

  assign from_rel = |rel_q;
  assign pool     = from_rel ? rel_q : evt_q;
  assign load     = en_i && (|pool) && (!msg_valid_o || msg_ready_i);

  always_comb begin
    grant = '0;
    for (int v = NUM_VEC - 1; v >= 0; v--) begin
      if (pool[v]) begin
        grant    = '0;
        grant[v] = 1'b1;
      end
    end
  end

  always_comb begin
    sel = '0;
    unused_ctrl = 1'b0;
    for (int v = 0; v < NUM_VEC; v++) begin
      if (grant[v]) sel = tbl_i[v];
      unused_ctrl ^= ^tbl_i[v].ctrl;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      evt_q <= '0;
      rel_q <= '0;
    end else begin
      rel_q <= (rel_q & ~((load && from_rel) ? grant : '0)) | rel_i;
      evt_q <= (evt_q & ~((load && !from_rel) ? grant : '0)) | fire_i;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      msg_valid_o <= 1'b0;
      msg_addr_o  <= '0;
      msg_data_o  <= '0;
    end else if (load) begin
      msg_valid_o <= 1'b1;
      msg_addr_o  <= {sel.hi, sel.lo};
      msg_data_o  <= sel.data;
    end else if (msg_ready_i) begin
      msg_valid_o <= 1'b0;
    end
  end

  p_msg_hold_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (msg_valid_o && !msg_ready_i) |=>
      (msg_valid_o && $stable(msg_addr_o) && $stable(msg_data_o)));

  p_no_start_disabled_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !en_i |=> !$rose(msg_valid_o));

  p_one_grant_r11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0(grant));

  p_release_first_r11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (load && (rel_q != '0)) |-> ((grant & rel_q) != '0));
endmodule

// File: rtl/irq_vector_table.sv
module irq_vector_table
  import ivt_pkg::*;
#(
  parameter int NUM_VEC = 8,
  parameter int CNT_W   = 4,
  parameter int ADDR_W  = 32
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               reg_req_i,
  input  logic               reg_we_i,
  input  logic [1:0]         reg_size_i,
  input  logic [ADDR_W-1:0]  reg_addr_i,
  input  logic [31:0]        reg_wdata_i,
  output logic [31:0]        reg_rdata_o,
  input  logic [MAX_VEC-1:0] evt_req_i,
  input  logic [1:0]         use_op_i,
  input  logic [VEC_W-1:0]   use_vec_i,
  output logic               msg_valid_o,
  input  logic               msg_ready_i,
  output logic [63:0]        msg_addr_o,
  output logic [31:0]        msg_data_o
);
  logic               wr, en, unused_bits;
  logic [9:0]         waddr;
  logic [NUM_VEC-1:0] in_use, drop, fire, rel;
  ivt_entry_t         tbl [NUM_VEC];

  assign wr    = reg_req_i && reg_we_i && (reg_size_i == SZ_WORD);
  assign waddr = reg_addr_i[11:2];
  assign unused_bits = ^{reg_addr_i[ADDR_W-1:12], reg_addr_i[1:0], evt_req_i};

  ivt_use_track #(.NUM_VEC(NUM_VEC), .CNT_W(CNT_W)) u_use (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .op_i     (use_op_e'(use_op_i)),
    .vec_i    (use_vec_i),
    .in_use_o (in_use),
    .drop_o   (drop)
  );

  ivt_table #(.NUM_VEC(NUM_VEC)) u_table (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .wr_i     (wr),
    .waddr_i  (waddr),
    .wdata_i  (reg_wdata_i),
    .rdata_o  (reg_rdata_o),
    .evt_i    (evt_req_i[NUM_VEC-1:0]),
    .in_use_i (in_use),
    .drop_i   (drop),
    .en_o     (en),
    .fire_o   (fire),
    .rel_o    (rel),
    .tbl_o    (tbl)
  );

  ivt_dispatch #(.NUM_VEC(NUM_VEC)) u_disp (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .en_i        (en),
    .fire_i      (fire),
    .rel_i       (rel),
    .tbl_i       (tbl),
    .msg_valid_o (msg_valid_o),
    .msg_ready_i (msg_ready_i),
    .msg_addr_o  (msg_addr_o),
    .msg_data_o  (msg_data_o)
  );
endmodule

// File: tb/irq_vector_table_tb_top.sv
module irq_vector_table_tb_top;
  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic        reg_req_i = 1'b0, reg_we_i = 1'b0;
  logic [1:0]  reg_size_i = 2'd2;
  logic [31:0] reg_addr_i = '0, reg_wdata_i = '0, reg_rdata_o;
  logic [31:0] evt_req_i = '0;
  logic [1:0]  use_op_i = '0;
  logic [4:0]  use_vec_i = '0;
  logic        msg_valid_o, msg_ready_i = 1'b0;
  logic [63:0] msg_addr_o;
  logic [31:0] msg_data_o;

  int n_tests = 0, n_fail = 0;
  bit done = 0;

  irq_vector_table dut_i (.*);

  always #4 clk_i = ~clk_i;

  typedef struct packed {
    logic [1:0]  sz;
    logic [31:0] waddr;
    logic [31:0] wdata;
    logic [31:0] raddr;
    logic [31:0] exp;
    logic [7:0]  req;
  } vec_t;

  localparam vec_t VECS [10] = '{
    '{2'd2, 32'h000, 32'h1111_0000, 32'h000, 32'h1111_0000, 8'd1}, // R1 addr low
    '{2'd2, 32'h004, 32'h0000_2222, 32'h004, 32'h0000_2222, 8'd1}, // R1 addr high
    '{2'd2, 32'h01A, 32'h0000_ABCD, 32'h018, 32'h0000_ABCD, 8'd3}, // R3 low bits ignored
    '{2'd0, 32'h1018, 32'h0000_5555, 32'h018, 32'h0000_ABCD, 8'd3}, // R3 byte no write
    '{2'd2, 32'h1024, 32'h0000_0077, 32'h024, 32'h0000_0077, 8'd3}, // R3 modulo 4 KB
    '{2'd2, 32'h01C, 32'hFFFF_FFF0, 32'h01C, 32'hFFFF_FFF0, 8'd1}, // R1 control word
    '{2'd2, 32'h080, 32'h0000_0099, 32'h080, 32'h0000_0000, 8'd12}, // R12 beyond entries
    '{2'd2, 32'hFFC, 32'hFFFF_FFFF, 32'hFFC, 32'h0000_8007, 8'd4}, // R4 enable only
    '{2'd2, 32'h800, 32'h0000_00FF, 32'h800, 32'h0000_0000, 8'd2}, // R2 read-only
    '{2'd2, 32'hFFC, 32'h0000_0000, 32'hFFC, 32'h0000_0007, 8'd4}  // R4 clear enable
  };

  task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
    n_tests++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic bus_wr(input logic [31:0] a, input logic [31:0] d, input logic [1:0] sz = 2'd2);
    @(negedge clk_i);
    reg_req_i = 1'b1; reg_we_i = 1'b1; reg_addr_i = a; reg_wdata_i = d; reg_size_i = sz;
    @(negedge clk_i);
    reg_req_i = 1'b0; reg_we_i = 1'b0; reg_size_i = 2'd2;
  endtask

  task automatic bus_rd(input logic [31:0] a, output logic [31:0] d);
    @(negedge clk_i);
    reg_addr_i = a;
    #1 d = reg_rdata_o;
  endtask

  task automatic rd_chk(input string tag, input logic [31:0] a, input logic [31:0] exp);
    logic [31:0] d;
    bus_rd(a, d);
    chk(tag, 64'(d), 64'(exp));
  endtask

  task automatic fire(input logic [31:0] m);
    @(negedge clk_i); evt_req_i = m;
    @(negedge clk_i); evt_req_i = '0;
  endtask

  task automatic use_cmd(input logic [1:0] op, input logic [4:0] v);
    @(negedge clk_i); use_op_i = op; use_vec_i = v;
    @(negedge clk_i); use_op_i = 2'd0;
  endtask

  task automatic expect_msg(input string tag, input logic [63:0] a, input logic [31:0] d);
    bit seen = 0;
    for (int i = 0; i < 10 && !seen; i++) begin
      @(negedge clk_i);
      if (msg_valid_o) seen = 1;
    end
    chk({tag, " valid"}, 64'(seen), 64'd1);
    if (seen) begin
      chk({tag, " addr"}, msg_addr_o, a);
      chk({tag, " data"}, 64'(msg_data_o), 64'(d));
      msg_ready_i = 1'b1;
      @(negedge clk_i);
      msg_ready_i = 1'b0;
    end
  endtask

  task automatic expect_none(input string tag);
    bit seen = 0;
    for (int i = 0; i < 8; i++) begin
      @(negedge clk_i);
      if (msg_valid_o) seen = 1;
    end
    chk(tag, 64'(seen), 64'd0);
  endtask

  task automatic do_reset();
    @(negedge clk_i); rst_ni = 1'b0;
    repeat (2) @(negedge clk_i);
    rst_ni = 1'b1;
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  endtask

  localparam logic [63:0] A2 = 64'h0000_0002_2000_0020;
  localparam logic [63:0] A3 = 64'h0000_0003_1000_0030;
  localparam logic [63:0] A5 = 64'h0000_0005_5000_0050;

  initial begin
    repeat (50000) @(posedge clk_i);
    n_tests++; n_fail++;
    $display("FAIL watchdog expired");
    finish_run();
  end

  initial begin
    do_reset();
    // R8 reset state
    chk("R8 msg_valid", 64'(msg_valid_o), 64'd0);
    rd_chk("R8 ctrl0 masked", 32'h00C, 32'h1);
    rd_chk("R8 ctrl7 masked", 32'h07C, 32'h1);
    rd_chk("R8 addr low zero", 32'h000, 32'h0);
    rd_chk("R8 pending zero", 32'h800, 32'h0);
    rd_chk("R8 flags", 32'hFFC, 32'h7);

    foreach (VECS[i]) begin
      logic [31:0] d;
      bus_wr(VECS[i].waddr, VECS[i].wdata, VECS[i].sz);
      bus_rd(VECS[i].raddr, d);
      chk($sformatf("table[%0d] R%0d", i, VECS[i].req), 64'(d), 64'(VECS[i].exp));
    end

    do_reset();
    rd_chk("R8 payload cleared", 32'h018, 32'h0);
    rd_chk("R8 mask restored", 32'h01C, 32'h1);

    bus_wr(32'hFFC, 32'h8000);
    bus_wr(32'h020, 32'h2000_0020); bus_wr(32'h024, 32'h2); bus_wr(32'h028, 32'hD2);
    bus_wr(32'h030, 32'h1000_0030); bus_wr(32'h034, 32'h3); bus_wr(32'h038, 32'hD3);
    bus_wr(32'h03C, 32'h0);
    bus_wr(32'h050, 32'h5000_0050); bus_wr(32'h054, 32'h5); bus_wr(32'h058, 32'hD5);
    bus_wr(32'h05C, 32'h0);

    fire(32'h8);
    expect_none("R5 unused vector dropped");
    use_cmd(2'd1, 5'd3); use_cmd(2'd1, 5'd5); use_cmd(2'd1, 5'd2);
    fire(32'h200);
    expect_none("R5 vector above count dropped");

    fire(32'h8);
    expect_msg("R6 unmasked delivery", A3, 32'hD3);
    fire(32'h4);
    expect_none("R6 masked no message");
    rd_chk("R6 pending set", 32'h800, 32'h4);
    bus_wr(32'h02C, 32'h0);
    expect_msg("R7 release on unmask", A2, 32'hD2);
    rd_chk("R7 pending cleared", 32'h800, 32'h0);

    // ordering with a stalled port
    bus_wr(32'h02C, 32'h1);
    fire(32'h4);
    rd_chk("R6 pending again", 32'h800, 32'h4);
    fire(32'h28);
    bus_wr(32'h02C, 32'h0);
    repeat (3) @(negedge clk_i);
    chk("R10 held valid", 64'(msg_valid_o), 64'd1);
    chk("R10 held addr", msg_addr_o, A3);
    expect_msg("R11 lowest request first", A3, 32'hD3);
    expect_msg("R11 release before queued", A2, 32'hD2);
    expect_msg("R11 remaining request", A5, 32'hD5);

    bus_wr(32'hFFC, 32'h0);
    bus_wr(32'h02C, 32'h1);
    fire(32'hC);
    expect_none("R5 disabled drops");
    rd_chk("R5 disabled no pending", 32'h800, 32'h0);
    bus_wr(32'hFFC, 32'h8000);
    rd_chk("R4 enable readback", 32'hFFC, 32'h8007);
    expect_none("R5 nothing queued while disabled");

    fire(32'h4);
    rd_chk("R9 pending before unuse", 32'h800, 32'h4);
    use_cmd(2'd2, 5'd2);
    rd_chk("R9 unuse clears pending", 32'h800, 32'h0);
    fire(32'h4);
    rd_chk("R9 unused stays clear", 32'h800, 32'h0);
    bus_wr(32'h02C, 32'h0);
    expect_none("R9 no release after unuse");
    use_cmd(2'd1, 5'd5); use_cmd(2'd2, 5'd5);
    fire(32'h20);
    expect_msg("R9 count still nonzero", A5, 32'hD5);
    bus_wr(32'h03C, 32'h1);
    fire(32'h8);
    rd_chk("R9 pending before clear", 32'h800, 32'h8);
    use_cmd(2'd3, 5'd0);
    rd_chk("R9 clear all pending", 32'h800, 32'h0);
    fire(32'h20);
    expect_none("R9 clear all drops use");

    finish_run();
  end
endmodule